// File: doc/BRIEF.md
# Scatter-Accumulate Orientation Template Encoder

The block turns a raster stream of 8-bit energy samples into a one-bit orientation template and a one-bit validity mask per pixel. It applies two 9x9 kernels, one that responds to vertical ridges and one that responds to horizontal ridges. It does not collect a 9x9 window for each output. Each arriving sample is multiplied by every coefficient of both kernels, and each product is added into the partial sum of the output pixel it influences. The image is treated as a torus, so taps that run past an edge land on the opposite row or column.

Partial sums are kept by kernel row. Each of the nine row groups owns a simple dual-port memory per kernel and is stepped through its nine column taps by a shared sequencer, which gives one read-modify-write per tap. A small input FIFO sits ahead of the array. The wrap-around means no pixel is final until the whole frame has arrived. After the last sample, the nine row memories are summed per pixel, the two totals are compared, and results stream out in raster order. The memories are cleared as they are read, so the next frame can follow at once.

The controller is a state machine with six states. S_CLEAR zeroes every memory location after reset and then moves to S_FETCH. S_FETCH waits for the FIFO and pops one sample into S_READ. S_READ issues the tap read and always moves to S_WRITE. S_WRITE adds the products and returns to S_READ for the next tap. After the ninth tap it goes to S_FETCH, or to S_EMIT if the sample was the last of the frame. S_EMIT sweeps the pixels, reading and clearing each one, and moves to S_FLUSH after the last one. S_FLUSH lets the final result leave the pipeline and returns to S_FETCH.

Top module: `sdf_encoder`

## Requirements
- R1: While reset is held and just after it, out_valid and frame_done are 0 and in_ready is 1.
- R2: A sample is taken on a clock edge where in_valid and in_ready are both 1. in_ready is 0 while the input FIFO holds FIFO_DEPTH samples. No sample is consumed while memories are being cleared after reset, so FIFO_DEPTH back-to-back samples drive in_ready low.
- R3: With samples s[r][c] taken in raster order (c fastest), the vertical response is V(y,x) = sum over i,j in 0..8 of KV[i][j]*s[(y+i-4) mod ROWS][(x+j-4) mod COLS]. H uses KH in the same way. Indices wrap on both axes.
- R4: out_bit is 1 when V > H and 0 otherwise. Equal responses give 0.
- R5: out_mask is 1 when V > THRESH or H > THRESH, both compared as signed and strictly greater. It is 0 when neither exceeds THRESH.
- R6: For each frame, exactly ROWS*COLS results appear in raster order on consecutive cycles after the frame's last sample. frame_done is 1 together with the last result only.
- R7: Each frame starts from zero partial sums. Results of back-to-back frames depend only on their own samples.
- R8: Coefficients are signed 8-bit and packed with entry i*9+j (i = kernel row, j = kernel column) at bits [(i*9+j)*8 +: 8]. The defaults are KV[i][j] = 2 when |j-4| <= 1, else -1, and KH[i][j] = 2 when |i-4| <= 1, else -1.
- R9: No result is emitted before the first frame has been fully received, and out_valid drops in the cycle after frame_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | FIFO has room |
| in_data | input | DATA_W | Energy sample, unsigned |
| out_valid | output | 1 | Result valid this cycle |
| out_bit | output | 1 | Orientation bit, 1 = vertical stronger |
| out_mask | output | 1 | Validity bit, 1 = a response exceeds THRESH |
| frame_done | output | 1 | Marks the last result of a frame |

## Verification
The assertions take for granted that in_valid is only relevant together with in_ready, and that every frame delivers exactly ROWS*COLS samples before the next frame begins. The bench always sends whole frames, holds in_valid and in_data steady until in_ready accepts them, and varies only the idle gaps between samples. It checks every result against a model computed in the bench. The stimulus mixes seeded random frames with zero, impulse and stripe frames, which exercise edge wrap, ties and the threshold.

// File: rtl/sdf_pkg.sv
package sdf_pkg;
    localparam int KDIM   = 9;
    localparam int KTAPS  = KDIM * KDIM;
    localparam int KCTR   = KDIM / 2;
    localparam int COEF_W = 8;
    localparam int TAP_W  = $clog2(KDIM);

    typedef enum logic [2:0] {
        S_CLEAR,
        S_FETCH,
        S_READ,
        S_WRITE,
        S_EMIT,
        S_FLUSH
    } sdf_state_e;

    // Ridge kernel: weight 2 on the three centre lines along the ridge, -1 elsewhere.
    function automatic logic [KTAPS*COEF_W-1:0] ridge_kernel(input logic vertical);
        logic [KTAPS*COEF_W-1:0] k;
        k = '0;
        for (int i = 0; i < KDIM; i++) begin
            for (int j = 0; j < KDIM; j++) begin
                int d;
                d = vertical ? (j - KCTR) : (i - KCTR);
                if (d < 0) d = -d;
                k[(i*KDIM+j)*COEF_W +: COEF_W] = (d <= 1) ? COEF_W'(2) : COEF_W'(-1);
            end
        end
        return k;
    endfunction

    // Reduce v (0 <= v < 3n) into 0..n-1.
    function automatic int wrap_idx(input int v, input int n);
        int r;
        r = v;
        if (r >= n) r = r - n;
        if (r >= n) r = r - n;
        return r;
    endfunction
endpackage

// File: rtl/sdf_fifo.sv
module sdf_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4,
    parameter int LW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic          full,
    output logic          empty,
    output logic [LW-1:0] level
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic          push_ok, pop_ok;

    assign full    = (level == LW'(DEPTH));
    assign empty   = (level == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign dout    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push_ok) begin
                mem[wr_ptr] <= din;
                wr_ptr <= (wr_ptr == PW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
            end
            if (pop_ok)
                rd_ptr <= (rd_ptr == PW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
            if (push_ok && !pop_ok)
                level <= level + 1'b1;
            else if (pop_ok && !push_ok)
                level <= level - 1'b1;
        end
    end
endmodule

// File: rtl/sdf_row_group.sv
module sdf_row_group
    import sdf_pkg::*;
#(
    parameter int ROW_IDX = 0,
    parameter int NPIX    = 192,
    parameter int AW      = 8,
    parameter int DATA_W  = 8,
    parameter int ACC_W   = 23,
    parameter logic [KTAPS*COEF_W-1:0] KV = ridge_kernel(1'b1),
    parameter logic [KTAPS*COEF_W-1:0] KH = ridge_kernel(1'b0)
) (
    input  logic                    clk,
    input  logic [AW-1:0]           addr,
    input  logic                    we,
    input  logic                    clr,
    input  logic [DATA_W-1:0]       sample,
    input  logic [TAP_W-1:0]        tap,
    output logic signed [ACC_W-1:0] rd_v,
    output logic signed [ACC_W-1:0] rd_h
);
    logic signed [ACC_W-1:0]  mem_v [NPIX];
    logic signed [ACC_W-1:0]  mem_h [NPIX];
    logic signed [COEF_W-1:0] cv, ch;
    logic signed [DATA_W:0]   s_ext;
    logic signed [ACC_W-1:0]  pv, ph, wv, wh;

    always_comb begin
        cv    = KV[(ROW_IDX*KDIM + int'(tap))*COEF_W +: COEF_W];
        ch    = KH[(ROW_IDX*KDIM + int'(tap))*COEF_W +: COEF_W];
        s_ext = $signed({1'b0, sample});
        pv    = ACC_W'(s_ext * cv);
        ph    = ACC_W'(s_ext * ch);
        wv    = clr ? '0 : rd_v + pv;
        wh    = clr ? '0 : rd_h + ph;
    end

    always_ff @(posedge clk) begin
        if (we) begin
            mem_v[addr] <= wv;
            mem_h[addr] <= wh;
        end
        rd_v <= mem_v[addr];
        rd_h <= mem_h[addr];
    end
endmodule

// File: rtl/sdf_encoder.sv
module sdf_encoder
    import sdf_pkg::*;
#(
    parameter int ROWS       = 12,
    parameter int COLS       = 16,
    parameter int DATA_W     = 8,
    parameter int FIFO_DEPTH = 4,
    parameter int THRESH     = 300,
    parameter logic [KTAPS*COEF_W-1:0] KV = ridge_kernel(1'b1),
    parameter logic [KTAPS*COEF_W-1:0] KH = ridge_kernel(1'b0)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic              out_bit,
    output logic              out_mask,
    output logic              frame_done
);
    localparam int NPIX  = ROWS * COLS;
    localparam int AW    = $clog2(NPIX);
    localparam int RW    = $clog2(ROWS);
    localparam int CW    = $clog2(COLS);
    localparam int LW    = $clog2(FIFO_DEPTH + 1);
    localparam int ACC_W = DATA_W + COEF_W + $clog2(KTAPS);

    sdf_state_e state, state_nx;

    logic [DATA_W-1:0] fifo_dout, sample_q;
    logic              fifo_full, fifo_empty, fifo_pop;
    logic [LW-1:0]     fifo_level;
    logic [RW-1:0]     in_row;
    logic [CW-1:0]     in_col;
    logic [TAP_W-1:0]  tap;
    logic [AW-1:0]     sweep;
    logic              sweep_mode, mem_we, mem_clr;
    logic              last_tap, last_pix, sweep_end;
    logic              emit_q, emit_last_q;

    logic signed [ACC_W-1:0] rv_all [KDIM];
    logic signed [ACC_W-1:0] rh_all [KDIM];
    logic signed [ACC_W-1:0] v_sum, h_sum;

    sdf_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH), .LW(LW)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (in_valid),
        .din   (in_data),
        .pop   (fifo_pop),
        .dout  (fifo_dout),
        .full  (fifo_full),
        .empty (fifo_empty),
        .level (fifo_level)
    );

    assign in_ready   = !fifo_full;
    assign fifo_pop   = (state == S_FETCH) && !fifo_empty;
    assign sweep_mode = (state == S_CLEAR) || (state == S_EMIT);
    assign mem_we     = sweep_mode || (state == S_WRITE);
    assign mem_clr    = sweep_mode;
    assign last_tap   = (tap == TAP_W'(KDIM-1));
    assign last_pix   = (in_row == RW'(ROWS-1)) && (in_col == CW'(COLS-1));
    assign sweep_end  = (sweep == AW'(NPIX-1));

    // One row group per kernel row, each with its own partial-sum memories.
    for (genvar g = 0; g < KDIM; g++) begin : g_row
        logic [AW-1:0] addr_g;
        always_comb begin
            int rr, cc;
            rr = wrap_idx(int'(in_row) + ROWS + KCTR - g, ROWS);
            cc = wrap_idx(int'(in_col) + COLS + KCTR - int'(tap), COLS);
            addr_g = sweep_mode ? sweep : AW'(rr * COLS + cc);
        end

        sdf_row_group #(
            .ROW_IDX (g),
            .NPIX    (NPIX),
            .AW      (AW),
            .DATA_W  (DATA_W),
            .ACC_W   (ACC_W),
            .KV      (KV),
            .KH      (KH)
        ) u_grp (
            .clk    (clk),
            .addr   (addr_g),
            .we     (mem_we),
            .clr    (mem_clr),
            .sample (sample_q),
            .tap    (tap),
            .rd_v   (rv_all[g]),
            .rd_h   (rh_all[g])
        );
    end

    always_comb begin
        v_sum = '0;
        h_sum = '0;
        for (int g = 0; g < KDIM; g++) begin
            v_sum = v_sum + rv_all[g];
            h_sum = h_sum + rh_all[g];
        end
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_CLEAR: if (sweep_end) state_nx = S_FETCH;
            S_FETCH: if (!fifo_empty) state_nx = S_READ;
            S_READ:  state_nx = S_WRITE;
            S_WRITE: begin
                if (!last_tap)     state_nx = S_READ;
                else if (last_pix) state_nx = S_EMIT;
                else               state_nx = S_FETCH;
            end
            S_EMIT:  if (sweep_end) state_nx = S_FLUSH;
            S_FLUSH: state_nx = S_FETCH;
            default: state_nx = S_CLEAR;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_CLEAR;
        else        state <= state_nx;
    end

    // Sequencing counters: sweep address, tap index, raster position
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sweep    <= '0;
            tap      <= '0;
            in_row   <= '0;
            in_col   <= '0;
            sample_q <= '0;
        end else begin
            if (sweep_mode)
                sweep <= sweep_end ? '0 : sweep + 1'b1;
            if (fifo_pop) begin
                sample_q <= fifo_dout;
                tap      <= '0;
            end
            if (state == S_WRITE) begin
                if (!last_tap) begin
                    tap <= tap + 1'b1;
                end else if (in_col == CW'(COLS-1)) begin
                    in_col <= '0;
                    in_row <= (in_row == RW'(ROWS-1)) ? '0 : in_row + 1'b1;
                end else begin
                    in_col <= in_col + 1'b1;
                end
            end
        end
    end

    // Outputs: read data valid one cycle after the sweep address, result one later
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            emit_q      <= 1'b0;
            emit_last_q <= 1'b0;
            out_valid   <= 1'b0;
            out_bit     <= 1'b0;
            out_mask    <= 1'b0;
            frame_done  <= 1'b0;
        end else begin
            emit_q      <= (state == S_EMIT);
            emit_last_q <= (state == S_EMIT) && sweep_end;
            out_valid   <= emit_q;
            out_bit     <= emit_q && (v_sum > h_sum);
            out_mask    <= emit_q && ((v_sum > ACC_W'(THRESH)) || (h_sum > ACC_W'(THRESH)));
            frame_done  <= emit_q && emit_last_q;
        end
    end
endmodule

// File: rtl/sdf_encoder_chk.sv
module sdf_encoder_chk #(
    parameter int NPIX       = 192,
    parameter int FIFO_DEPTH = 4,
    parameter int LW         = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_ready,
    input logic          out_valid,
    input logic          frame_done,
    input logic [LW-1:0] fifo_level
);
    int unsigned out_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)          out_cnt <= 0;
        else if (frame_done) out_cnt <= 0;
        else if (out_valid)  out_cnt <= out_cnt + 1;
    end

    p_level_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        int'(fifo_level) <= FIFO_DEPTH);

    p_ready_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(fifo_level) == FIFO_DEPTH) |-> !in_ready);

    p_done_in_stream_r6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> out_valid);

    p_stream_contig_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !frame_done) |=> out_valid);

    p_frame_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> (out_cnt == NPIX - 1));

    p_quiet_after_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !out_valid);
endmodule

bind sdf_encoder sdf_encoder_chk #(
    .NPIX       (NPIX),
    .FIFO_DEPTH (FIFO_DEPTH),
    .LW         (LW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .frame_done (frame_done),
    .fifo_level (fifo_level)
);

// File: tb/sdf_encoder_tb.sv
module sdf_encoder_tb;
    localparam int ROWS   = 12;
    localparam int COLS   = 16;
    localparam int NPIX   = ROWS * COLS;
    localparam int DEPTH  = 4;
    localparam int THRESH = 300;
    localparam int NF     = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_ready, out_valid, out_bit, out_mask, frame_done;

    int frm [NF][NPIX];
    int checks = 0;
    int fails = 0;
    int mf = 0;
    int mp = 0;
    bit first_sent = 1'b0;
    bit early_out = 1'b0;

    always #5 clk = ~clk;

    sdf_encoder #(.ROWS(ROWS), .COLS(COLS), .FIFO_DEPTH(DEPTH), .THRESH(THRESH)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .out_valid(out_valid), .out_bit(out_bit),
        .out_mask(out_mask), .frame_done(frame_done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (frame %0d pixel %0d)", req, act, exp, mf, mp);
        end
    endtask

    // R8 coefficient rule
    function automatic int kcoef(input bit vert, input int i, input int j);
        int d;
        d = vert ? (j - 4) : (i - 4);
        if (d < 0) d = -d;
        return (d <= 1) ? 2 : -1;
    endfunction

    // R3 response with wrap on both axes
    function automatic int resp(input int f, input bit vert, input int y, input int x);
        int s;
        s = 0;
        for (int i = 0; i < 9; i++)
            for (int j = 0; j < 9; j++)
                s += kcoef(vert, i, j) * frm[f][((y+i-4+ROWS)%ROWS)*COLS + ((x+j-4+COLS)%COLS)];
        return s;
    endfunction

    function automatic string bit_req(input int f);
        case (f)
            1: return "R7 R4";
            2: return "R8 R3";
            3, 4: return "R3 R4";
            default: return "R4";
        endcase
    endfunction

    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (!first_sent) early_out = 1'b1;
            if (mf >= NF) begin
                check(1'b0, "R6 extra output", 1, 0);
            end else begin
                int v, h, y, x;
                y = mp / COLS;
                x = mp % COLS;
                v = resp(mf, 1'b1, y, x);
                h = resp(mf, 1'b0, y, x);
                check(out_bit == (v > h), bit_req(mf), int'(out_bit), int'(v > h));
                check(out_mask == ((v > THRESH) || (h > THRESH)), "R5 mask",
                      int'(out_mask), int'((v > THRESH) || (h > THRESH)));
                check(frame_done == (mp == NPIX-1), "R6 frame_done",
                      int'(frame_done), int'(mp == NPIX-1));
                mp++;
                if (mp == NPIX) begin
                    mp = 0;
                    mf++;
                end
            end
        end
    end

    task automatic push(input int d, input int gap);
        for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = d[7:0];
        while (!in_ready) @(negedge clk);
    endtask

    initial begin
        for (int c = 0; c < 180000; c++) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d frames", mf, NF);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h0005_EED1));
        for (int p = 0; p < NPIX; p++) begin
            int y, x;
            y = p / COLS;
            x = p % COLS;
            frm[0][p] = int'($urandom_range(0, 255));
            frm[1][p] = 0;
            frm[2][p] = (p == 0) ? 255 : ((p == NPIX-1) ? 200 : 0);
            frm[3][p] = (x % 3 == 0) ? 250 : 12;
            frm[4][p] = (y % 3 == 1) ? 240 : 5;
            frm[5][p] = int'($urandom_range(0, 255));
        end

        repeat (3) @(negedge clk);
        check(out_valid == 1'b0 && frame_done == 1'b0, "R1 outputs idle in reset",
              int'(out_valid) + int'(frame_done), 0);
        check(in_ready == 1'b1, "R1 ready in reset", int'(in_ready), 1);
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready == 1'b1, "R1 ready after reset", int'(in_ready), 1);

        for (int f = 0; f < NF; f++) begin
            for (int p = 0; p < NPIX; p++) begin
                if (f == 0 && p == DEPTH) begin
                    @(negedge clk);
                    check(in_ready == 1'b0, "R2 ready low when FIFO full", int'(in_ready), 0);
                end
                push(frm[f][p], (f == 0 && p < DEPTH) || f == NF-1 ? 0 : int'($urandom_range(0, 2)));
            end
            @(negedge clk);
            in_valid = 1'b0;
            if (f == 0) begin
                // R9: nothing may appear before the whole first frame is in
                check(early_out == 1'b0, "R9 no early output", int'(early_out), 0);
                first_sent = 1'b1;
            end
        end

        for (int c = 0; c < 20000 && mf < NF; c++) @(negedge clk);
        check(mf == NF, "R6 all frames emitted", mf, NF);
        repeat (5) @(negedge clk);
        check(out_valid == 1'b0, "R9 idle after last frame", int'(out_valid), 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule